// File: doc/BRIEF.md
# Chained Up/Down Binary Counter

This block is a binary counter built from a row of identical 4-bit stages. Each stage counts up or down. It hands a step enable to the next, more significant stage through a carry line when counting up and a borrow line when counting down. The number of stages is a parameter. The exposed count is four bits wide per stage, and the first stage holds the least significant bits.

An active-low load input forces the whole count to a parallel load value at once, with no clock edge needed. Counting stops while the load is held. When the load is released, counting continues from the loaded value in the selected direction.

Two active-high inputs set the direction. If both are high, or both are low, the count holds. The carry and borrow of the top stage are brought out so that a wider counter can be built from several of these blocks.

Top module: `updn_chain_ctr`

## Requirements
- R1: While `ld_n` is low, `count` equals `ld_val` without waiting for a clock edge.
- R2: While `ld_n` stays low, clock edges do not change `count`, whatever `up` and `dn` are.
- R3: After `ld_n` returns high, the next clock edge steps `count` from the loaded value in the selected direction.
- R4: With `up`=1 and `dn`=0, each rising clock edge sets `count` to (`count`+1) modulo 2^(4·STAGES).
- R5: With `up`=0 and `dn`=1, each rising clock edge sets `count` to (`count`−1) modulo 2^(4·STAGES).
- R6: With `up` and `dn` both high or both low, `count` keeps its value across clock edges.
- R7: Counting up carries across stage boundaries within a single edge. For example, 0x0FF steps to 0x100, and the all-ones value wraps to 0.
- R8: Counting down borrows across stage boundaries within a single edge. For example, 0x100 steps to 0x0FF, and 0 wraps to all ones.
- R9: `carry_out` is 1 exactly when `up`=1, `dn`=0 and `count` is all ones.
- R10: `borrow_out` is 1 exactly when `up`=0, `dn`=1 and `count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| ld_n | input | 1 | Active-low asynchronous parallel load |
| up | input | 1 | Count-up request, active high |
| dn | input | 1 | Count-down request, active high |
| ld_val | input | 4·STAGES | Parallel load value |
| count | output | 4·STAGES | Current count |
| carry_out | output | 1 | Top stage full while counting up |
| borrow_out | output | 1 | Top stage empty while counting down |

## Verification
Outside the load window, the checker confirms on every edge that the count steps by exactly one in the chosen direction or holds when the request is void. It also confirms on every cycle that the top carry and borrow match the count and the direction, which covers R4 through R10. The bench's scenarios cover what only the load can show: the count follows the load value between clock edges, it stays frozen over several edges, and it resumes from the loaded value. The scenarios also aim the count at each stage boundary and at both wrap points.

// File: rtl/updn_ctr_pkg.sv
package updn_ctr_pkg;
   localparam int unsigned SLICE_W = 4;

   typedef enum logic [1:0] {
      DIR_HOLD = 2'b00,
      DIR_INC  = 2'b01,
      DIR_DEC  = 2'b10
   } dir_e;
endpackage

// File: rtl/updn_dir_decode.sv
module updn_dir_decode
   import updn_ctr_pkg::*;
(
   input  logic up,
   input  logic dn,
   output dir_e dir
);
   always_comb begin
      unique case ({dn, up})
         2'b01:   dir = DIR_INC;
         2'b10:   dir = DIR_DEC;
         default: dir = DIR_HOLD;
      endcase
   end
endmodule

// File: rtl/updn_slice.sv
module updn_slice
   import updn_ctr_pkg::*;
#(
   parameter int unsigned W = SLICE_W
) (
   input  logic         clk,
   input  logic         ld_n,
   input  logic         en,
   input  dir_e         dir,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] q,
   output logic         co,
   output logic         bo
);
   localparam logic [W-1:0] FULL  = {W{1'b1}};
   localparam logic [W-1:0] EMPTY = '0;
   localparam logic [W-1:0] ONE   = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] q_reg;

   initial begin
      assert (W >= 1) else $error("slice width must be positive");
   end

   always_ff @(posedge clk or negedge ld_n) begin
      if (!ld_n) begin
         q_reg <= ld_val;
      end else if (en) begin
         case (dir)
            DIR_INC: q_reg <= q_reg + ONE;
            DIR_DEC: q_reg <= q_reg - ONE;
            default: q_reg <= q_reg;
         endcase
      end
   end

   // load value is transparent while the override is active
   assign q  = ld_n ? q_reg : ld_val;
   assign co = en && (dir == DIR_INC) && (q == FULL);
   assign bo = en && (dir == DIR_DEC) && (q == EMPTY);
endmodule

// File: rtl/updn_chain_ctr.sv
module updn_chain_ctr
   import updn_ctr_pkg::*;
#(
   parameter int unsigned STAGES = 3
) (
   input  logic                        clk,
   input  logic                        ld_n,
   input  logic                        up,
   input  logic                        dn,
   input  logic [SLICE_W*STAGES-1:0]   ld_val,
   output logic [SLICE_W*STAGES-1:0]   count,
   output logic                        carry_out,
   output logic                        borrow_out
);
   localparam int unsigned CW = SLICE_W * STAGES;

   initial begin
      assert (STAGES >= 1) else $error("STAGES must be at least 1");
   end

   dir_e dir;
   logic stage_en [STAGES+1];
   logic stage_co [STAGES];
   logic stage_bo [STAGES];

   updn_dir_decode u_dir (
      .up  (up),
      .dn  (dn),
      .dir (dir)
   );

   assign stage_en[0] = 1'b1;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      updn_slice #(.W(SLICE_W)) u_slice (
         .clk    (clk),
         .ld_n   (ld_n),
         .en     (stage_en[i]),
         .dir    (dir),
         .ld_val (ld_val[i*SLICE_W +: SLICE_W]),
         .q      (count[i*SLICE_W +: SLICE_W]),
         .co     (stage_co[i]),
         .bo     (stage_bo[i])
      );
      assign stage_en[i+1] = stage_co[i] | stage_bo[i];
   end

   assign carry_out  = stage_co[STAGES-1];
   assign borrow_out = stage_bo[STAGES-1];

   logic unused_top_en;
   assign unused_top_en = stage_en[STAGES];
endmodule

// File: rtl/updn_chain_ctr_chk.sv
module updn_chain_ctr_chk #(
   parameter int unsigned CW = 12
) (
   input logic          clk,
   input logic          ld_n,
   input logic          up,
   input logic          dn,
   input logic [CW-1:0] count,
   input logic          carry_out,
   input logic          borrow_out
);
   localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

   AST_UP_STEP: assert property (@(posedge clk) disable iff (!ld_n)
      (up && !dn) |=> count == $past(count) + ONE);  // R4
   AST_DN_STEP: assert property (@(posedge clk) disable iff (!ld_n)
      (!up && dn) |=> count == $past(count) - ONE);  // R5
   AST_HOLD: assert property (@(posedge clk) disable iff (!ld_n)
      (up == dn) |=> $stable(count));  // R6
   AST_CARRY_OUT: assert property (@(posedge clk) disable iff (!ld_n)
      carry_out == (up && !dn && (&count)));  // R9
   AST_BORROW_OUT: assert property (@(posedge clk) disable iff (!ld_n)
      borrow_out == (!up && dn && (count == '0)));  // R10
   AST_ONE_CHAIN: assert property (@(posedge clk) disable iff (!ld_n)
      !(carry_out && borrow_out));  // R9
endmodule

bind updn_chain_ctr updn_chain_ctr_chk #(.CW(CW)) u_chk (
   .clk        (clk),
   .ld_n       (ld_n),
   .up         (up),
   .dn         (dn),
   .count      (count),
   .carry_out  (carry_out),
   .borrow_out (borrow_out)
);

// File: tb/sim_updn_chain_ctr.sv
`timescale 1ns/1ps
module sim_updn_chain_ctr;
   localparam int STAGES = 3;
   localparam int CW = 4 * STAGES;
   localparam logic [CW-1:0] ALL1 = {CW{1'b1}};

   logic clk = 1'b0;
   logic ld_n, up, dn;
   logic [CW-1:0] ld_val;
   logic [CW-1:0] count;
   logic carry_out, borrow_out;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   updn_chain_ctr #(.STAGES(STAGES)) u0 (
      .clk(clk), .ld_n(ld_n), .up(up), .dn(dn), .ld_val(ld_val),
      .count(count), .carry_out(carry_out), .borrow_out(borrow_out)
   );

   task automatic chk(input string req, input logic [CW-1:0] got, input logic [CW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic edge1();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic load(input logic [CW-1:0] v);
      ld_val = v;
      ld_n = 1'b0;
      #1;
      chk("R1", count, v);
      edge1();
      ld_n = 1'b1;
   endtask

   task automatic t_reset_state();
      ld_n = 1'b0; up = 1'b0; dn = 1'b0; ld_val = '0;
      @(negedge clk);
      chk("R1", count, '0);
      chk("R9", {{(CW-1){1'b0}}, carry_out}, '0);
      chk("R10", {{(CW-1){1'b0}}, borrow_out}, '0);
      ld_n = 1'b1;
   endtask

   task automatic t_up_boundary();
      load(12'h0FE);
      up = 1'b1; dn = 1'b0;
      edge1(); chk("R3", count, 12'h0FF);
      edge1(); chk("R7", count, 12'h100);
      edge1(); chk("R4", count, 12'h101);
      load(12'hFFE);
      edge1(); chk("R4", count, 12'hFFF);
      chk("R9", {{(CW-1){1'b0}}, carry_out}, 1);
      edge1(); chk("R7", count, 12'h000);
      chk("R9", {{(CW-1){1'b0}}, carry_out}, 0);
      up = 1'b0;
   endtask

   task automatic t_dn_boundary();
      load(12'h101);
      up = 1'b0; dn = 1'b1;
      edge1(); chk("R5", count, 12'h100);
      edge1(); chk("R8", count, 12'h0FF);
      load(12'h001);
      edge1(); chk("R5", count, 12'h000);
      chk("R10", {{(CW-1){1'b0}}, borrow_out}, 1);
      edge1(); chk("R8", count, ALL1);
      chk("R10", {{(CW-1){1'b0}}, borrow_out}, 0);
      dn = 1'b0;
   endtask

   task automatic t_hold();
      load(12'h5A3);
      up = 1'b1; dn = 1'b1;
      edge1(); edge1(); chk("R6", count, 12'h5A3);
      chk("R9", {{(CW-1){1'b0}}, carry_out}, 0);
      up = 1'b0; dn = 1'b0;
      edge1(); chk("R6", count, 12'h5A3);
      load(12'hFFF);
      up = 1'b1; dn = 1'b1;
      edge1(); chk("R6", count, 12'hFFF);
      chk("R9", {{(CW-1){1'b0}}, carry_out}, 0);
      up = 1'b0; dn = 1'b0;
   endtask

   task automatic t_mid_load();
      load(12'h010);
      up = 1'b1; dn = 1'b0;
      edge1(); edge1(); chk("R4", count, 12'h012);
      #1;
      ld_val = 12'h7F0;
      ld_n = 1'b0;
      #0.5;
      chk("R1", count, 12'h7F0);
      edge1(); edge1(); edge1();
      chk("R2", count, 12'h7F0);
      up = 1'b0; dn = 1'b1;
      edge1(); chk("R2", count, 12'h7F0);
      ld_n = 1'b1;
      edge1(); chk("R3", count, 12'h7EF);
      up = 1'b1; dn = 1'b0;
      edge1(); chk("R3", count, 12'h7F0);
      up = 1'b0;
   endtask

   initial begin
      t_reset_state();
      t_up_boundary();
      t_dn_boundary();
      t_hold();
      t_mid_load();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule